// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a user request port and a byte-wide flash bus. When it accepts a request, it issues the unlock-and-command write sequence for one of four operations. These are a single byte program, a sector erase, a block erase or a full chip erase. It then polls the flash until the internal operation finishes. Completion is found by watching bit 6 of successive reads. While the flash is busy that bit alternates, and two reads in a row with equal bit 6 mean the flash has stopped.

The flash can finish at any moment between two reads, so the sequencer does not trust the read that ended the toggling. It reads the location twice more and reports success only when both of those reads hold the expected content. If the flash is still toggling after an operation-specific window of clock cycles, the sequencer writes the return-to-read command and reports a timeout. Only one operation is in flight at a time. The ready output stays low until the result has been reported.

Top module: `nvm_wr_ctrl`

## Requirements
- R1: In the idle state `req_ready` is high and neither flash strobe is active. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. From that edge until the result is reported, `req_ready` stays low and any `req_valid` has no effect on the bus or on the outcome.
- R2: `req_op` 2'b00 selects a byte program. It starts with write strobes on four consecutive cycles, beginning the cycle after acceptance: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then `req_data` at `req_addr`.
- R3: `req_op` 2'b01 selects a sector erase, 2'b10 a block erase and 2'b11 a chip erase. Each starts with six consecutive writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then a final command. The final command is 30h at `req_addr` with its low SECT_BITS cleared, 50h at `req_addr` with its low BLK_BITS cleared, or 10h at 5555h.
- R4: Polling starts the cycle after the last command write. A read strobe is raised every second cycle. The poll address is `req_addr` for program and chip erase, and the cleared base address for sector and block erase. The flash returns data in the cycle after the strobe. Toggling counts as stopped at the first read whose bit 6 equals bit 6 of the read before it.
- R5: After toggling stops, exactly two more reads are made. `pass` is 1 only if both of them are valid. A bad first confirmation read followed by a good second one still fails.
- R6: For a program, a read is valid when its bit 7 equals bit 7 of the programmed byte. For any erase, a read is valid when it is FFh.
- R7: The timeout window is PROG_CYC cycles for a program, ERASE_CYC cycles for a sector or block erase, and CHIP_CYC cycles for a chip erase. It is counted from the first poll read. Once the window has elapsed, no further read is issued. The next cycle carries a single write of F0h at 5555h, and then the result is reported with `timed_out`=1 and `pass`=0.
- R8: `done` is high for exactly one cycle. That cycle follows either the capture of the second confirmation read or the F0h write, and `pass` and `timed_out` are valid in it. `req_ready` returns high in the next cycle.
- R9: After reset, `req_ready` is 1 and `done`, `pass`, `timed_out`, `fl_we` and `fl_re` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High when a request can be taken |
| req_op | input | 2 | 00 program, 01 sector erase, 10 block erase, 11 chip erase |
| req_addr | input | AW | Target byte address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | Operation verified, valid with done |
| timed_out | output | 1 | Window expired, valid with done |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, valid the cycle after fl_re |

## Verification
Each of the four operations runs against a scripted flash reply sequence. Some replies stop toggling early and some late. In some, the toggling ends on a read that already holds final data, which separates correct stop detection from an off-by-one in the compare. The confirmation replies come in several forms: both good, both bad, and a bad read followed by a good one. These show whether both reads really gate `pass`, and whether the bit-7 rule is applied to programs and the FFh rule to erases. Two sector erases stop just inside and just outside the window, and flashes that toggle forever cover the program and chip windows. Together they pin down the exact cycle of the timeout and of the F0h write. A request held high during a busy operation shows that it is ignored.

// File: rtl/nvm_wr_pkg.sv
package nvm_wr_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_FIRST = 2'd0,
    PH_TOG   = 2'd1,
    PH_CF1   = 2'd2,
    PH_CF2   = 2'd3
  } phase_e;

  localparam logic [31:0] ADR_UNLK1 = 32'h0000_5555;
  localparam logic [31:0] ADR_UNLK2 = 32'h0000_2AAA;
  localparam logic [7:0]  CMD_RESET = 8'hF0;

  // number of command writes per operation
  function automatic logic [2:0] seq_len(op_e op);
    return (op == OP_PROG) ? 3'd4 : 3'd6;
  endfunction

  // address of command write number idx
  function automatic logic [31:0] cmd_addr(op_e op, logic [2:0] idx, logic [31:0] tgt);
    logic [31:0] a;
    case (idx)
      3'd1, 3'd4: a = ADR_UNLK2;
      3'd3:       a = (op == OP_PROG) ? tgt : ADR_UNLK1;
      3'd5:       a = (op == OP_CHIP) ? ADR_UNLK1 : tgt;
      default:    a = ADR_UNLK1;
    endcase
    return a;
  endfunction

  // data of command write number idx
  function automatic logic [7:0] cmd_data(op_e op, logic [2:0] idx, logic [7:0] d);
    logic [7:0] v;
    case (idx)
      3'd0:    v = 8'hAA;
      3'd1:    v = 8'h55;
      3'd2:    v = (op == OP_PROG) ? 8'hA0 : 8'h80;
      3'd3:    v = (op == OP_PROG) ? d : 8'hAA;
      3'd4:    v = 8'h55;
      default: begin
        case (op)
          OP_SECT: v = 8'h30;
          OP_BLK:  v = 8'h50;
          default: v = 8'h10;
        endcase
      end
    endcase
    return v;
  endfunction

  // location that is erased/programmed and later polled
  function automatic logic [31:0] poll_target(op_e op, logic [31:0] a, int sb, int bb);
    logic [31:0] m;
    case (op)
      OP_SECT: m = ~((32'd1 << sb) - 32'd1);
      OP_BLK:  m = ~((32'd1 << bb) - 32'd1);
      default: m = '1;
    endcase
    return a & m;
  endfunction

  function automatic logic readback_ok(op_e op, logic [7:0] wd, logic [7:0] rd);
    return (op == OP_PROG) ? (rd[7] == wd[7]) : (rd == 8'hFF);
  endfunction

endpackage

// File: rtl/nvm_tmo_timer.sv
module nvm_tmo_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt;

  assign hit = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (run && !hit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nvm_poll_judge.sv
module nvm_poll_judge
  import nvm_wr_pkg::*;
(
  input  op_e        op,
  input  logic [7:0] wdata,
  input  logic [7:0] rdata,
  input  logic       prev6,
  output logic       stopped,
  output logic       good
);
  assign stopped = (rdata[6] == prev6);
  assign good    = readback_ok(op, wdata, rdata);
endmodule

// File: rtl/nvm_wr_ctrl.sv
module nvm_wr_ctrl
  import nvm_wr_pkg::*;
#(
  parameter int AW        = 20,
  parameter int SECT_BITS = 12,
  parameter int BLK_BITS  = 16,
  parameter int CLK_KHZ   = 125000,
  parameter int PROG_CYC  = 32 * CLK_KHZ / 1000,
  parameter int ERASE_CYC = 32 * CLK_KHZ,
  parameter int CHIP_CYC  = 128 * CLK_KHZ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          done,
  output logic          pass,
  output logic          timed_out,
  output logic          fl_we,
  output logic          fl_re,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  input  logic [7:0]    fl_rdata
);
  localparam int TMO_A   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int TMO_MAX = (TMO_A > CHIP_CYC) ? TMO_A : CHIP_CYC;
  localparam int CW      = $clog2(TMO_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_CAP, S_ABORT, S_RPT} st_e;

  st_e           st;
  op_e           op_q;
  phase_e        ph;
  logic [AW-1:0] tgt_q;
  logic [7:0]    data_q;
  logic [2:0]    idx;
  logic          prev6, ok1, pass_q, tmo_q;
  logic [CW-1:0] lim;
  logic [31:0]   tgt32, ca;
  logic [7:0]    cd;

  // named internal events
  logic ev_accept, ev_wr_last, ev_poll_rd, ev_capture, ev_tmo_hit, ev_stopped, ev_good;

  assign ev_accept  = (st == S_IDLE) && req_valid;
  assign ev_wr_last = (st == S_WR) && (idx == seq_len(op_q) - 3'd1);
  assign ev_poll_rd = (st == S_RD);
  assign ev_capture = (st == S_CAP);

  always_comb begin
    case (op_q)
      OP_PROG: lim = CW'(PROG_CYC);
      OP_CHIP: lim = CW'(CHIP_CYC);
      default: lim = CW'(ERASE_CYC);
    endcase
  end

  nvm_tmo_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_wr_last),
    .run   (ev_poll_rd || ev_capture),
    .limit (lim),
    .hit   (ev_tmo_hit)
  );

  nvm_poll_judge u_judge (
    .op      (op_q),
    .wdata   (data_q),
    .rdata   (fl_rdata),
    .prev6   (prev6),
    .stopped (ev_stopped),
    .good    (ev_good)
  );

  assign tgt32 = poll_target(op_e'(req_op), 32'(req_addr), SECT_BITS, BLK_BITS);
  assign ca    = cmd_addr(op_q, idx, 32'(tgt_q));
  assign cd    = cmd_data(op_q, idx, data_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_PROG;
      ph     <= PH_FIRST;
      tgt_q  <= '0;
      data_q <= '0;
      idx    <= '0;
      prev6  <= 1'b0;
      ok1    <= 1'b0;
      pass_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (ev_accept) begin
          op_q   <= op_e'(req_op);
          tgt_q  <= tgt32[AW-1:0];
          data_q <= req_data;
          idx    <= '0;
          pass_q <= 1'b0;
          tmo_q  <= 1'b0;
          st     <= S_WR;
        end
        S_WR: begin
          idx <= idx + 3'd1;
          if (ev_wr_last) begin
            ph <= PH_FIRST;
            st <= S_RD;
          end
        end
        S_RD: st <= ev_tmo_hit ? S_ABORT : S_CAP;
        S_CAP: begin
          st <= S_RD;
          case (ph)
            PH_FIRST: begin
              prev6 <= fl_rdata[6];
              ph    <= PH_TOG;
            end
            PH_TOG: begin
              prev6 <= fl_rdata[6];
              if (ev_stopped) ph <= PH_CF1;
            end
            PH_CF1: begin
              ok1 <= ev_good;
              ph  <= PH_CF2;
            end
            default: begin
              pass_q <= ok1 && ev_good;
              st     <= S_RPT;
            end
          endcase
        end
        S_ABORT: begin
          tmo_q <= 1'b1;
          st    <= S_RPT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_RPT);
  assign pass      = pass_q;
  assign timed_out = tmo_q;
  assign fl_we     = (st == S_WR) || (st == S_ABORT);
  assign fl_re     = ev_poll_rd && !ev_tmo_hit;

  always_comb begin
    fl_addr  = '0;
    fl_wdata = '0;
    case (st)
      S_WR: begin
        fl_addr  = ca[AW-1:0];
        fl_wdata = cd;
      end
      S_RD:    fl_addr = tgt_q;
      S_ABORT: begin
        fl_addr  = ADR_UNLK1[AW-1:0];
        fl_wdata = CMD_RESET;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nvm_wr_ctrl_chk.sv
module nvm_wr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       pass,
  input logic       timed_out,
  input logic       fl_we,
  input logic       fl_re,
  input logic [7:0] fl_wdata,
  input logic       ev_poll_rd,
  input logic       ev_tmo_hit
);
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !fl_we && !fl_re);

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  a_r7_abort_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_poll_rd && ev_tmo_hit |=> fl_we && (fl_wdata == 8'hF0));

  a_r7_timeout_fails: assert property (@(posedge clk) disable iff (!rst_n)
    done && timed_out |-> !pass);

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready && !fl_we && !fl_re);
endmodule

bind nvm_wr_ctrl nvm_wr_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .done       (done),
  .pass       (pass),
  .timed_out  (timed_out),
  .fl_we      (fl_we),
  .fl_re      (fl_re),
  .fl_wdata   (fl_wdata),
  .ev_poll_rd (ev_poll_rd),
  .ev_tmo_hit (ev_tmo_hit)
);

// File: tb/nvm_wr_ctrl_bench.sv
module nvm_wr_ctrl_bench;
  localparam int AW = 20;
  localparam int LIM_PROG = 24;
  localparam int LIM_ERASE = 40;
  localparam int LIM_CHIP = 60;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          done, pass, timed_out, fl_we, fl_re;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata;
  logic [7:0]    fl_rdata = 8'h00;

  int n_cmp = 0;
  int n_bad = 0;
  bit running = 0;

  always #4 clk = ~clk;

  nvm_wr_ctrl #(.AW(AW), .PROG_CYC(LIM_PROG), .ERASE_CYC(LIM_ERASE), .CHIP_CYC(LIM_CHIP))
  u_nvm_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .done(done), .pass(pass), .timed_out(timed_out),
    .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata)
  );

  // ---------------- scripted flash stub ----------------
  int rsp_q[$];
  bit tog_forever = 0;
  int rdcnt = 0;

  function automatic int resp(int k);
    if (tog_forever) return (k % 2 == 1) ? 32'h40 : 32'h00;
    if (k < rsp_q.size()) return rsp_q[k];
    return rsp_q[rsp_q.size()-1];
  endfunction

  always @(posedge clk) begin
    if (fl_we) rdcnt = 0;
    if (fl_re) begin
      fl_rdata <= 8'(resp(rdcnt));
      rdcnt = rdcnt + 1;
    end
  end

  // ---------------- reference timeline ----------------
  typedef struct {
    bit we; bit re; int addr; int wd; bit dn; bit ps; bit to; string tag;
  } cyc_t;
  cyc_t exp_q[$];

  function automatic void push(bit we, bit re, int addr, int wd, bit dn, bit ps, bit to, string tag);
    cyc_t c;
    c.we = we; c.re = re; c.addr = addr; c.wd = wd; c.dn = dn; c.ps = ps; c.to = to; c.tag = tag;
    exp_q.push_back(c);
  endfunction

  function automatic bit valid_rd(int op, int data, int r);
    if (op == 0) return ((r >> 7) & 1) == ((data >> 7) & 1);
    return r == 32'hFF;
  endfunction

  function automatic void plan(int op, int addr, int data);
    int tgt, lim, stop;
    bit ok;
    tgt = addr;
    if (op == 1) tgt = addr & ~32'hFFF;
    if (op == 2) tgt = addr & ~32'hFFFF;
    lim = (op == 0) ? LIM_PROG : ((op == 3) ? LIM_CHIP : LIM_ERASE);
    push(1, 0, 32'h5555, 32'hAA, 0, 0, 0, "R2/R3 unlock1");
    push(1, 0, 32'h2AAA, 32'h55, 0, 0, 0, "R2/R3 unlock2");
    if (op == 0) begin
      push(1, 0, 32'h5555, 32'hA0, 0, 0, 0, "R2 program cmd");
      push(1, 0, addr, data, 0, 0, 0, "R2 program data");
    end else begin
      push(1, 0, 32'h5555, 32'h80, 0, 0, 0, "R3 erase setup");
      push(1, 0, 32'h5555, 32'hAA, 0, 0, 0, "R3 unlock3");
      push(1, 0, 32'h2AAA, 32'h55, 0, 0, 0, "R3 unlock4");
      if (op == 1) push(1, 0, tgt, 32'h30, 0, 0, 0, "R3 sector cmd");
      else if (op == 2) push(1, 0, tgt, 32'h50, 0, 0, 0, "R3 block cmd");
      else push(1, 0, 32'h5555, 32'h10, 0, 0, 0, "R3 chip cmd");
    end
    stop = -1;
    ok = 1;
    for (int k = 0; ; k++) begin
      if (2 * k >= lim) begin
        push(0, 0, 0, 0, 0, 0, 0, "R7 no read after window");
        push(1, 0, 32'h5555, 32'hF0, 0, 0, 0, "R7 abort write");
        push(0, 0, 0, 0, 1, 0, 1, "R7 timeout report");
        return;
      end
      push(0, 1, tgt, 0, 0, 0, 0, "R4 poll read");
      push(0, 0, 0, 0, 0, 0, 0, "R4 capture");
      if (stop < 0) begin
        if (k > 0 && (((resp(k) >> 6) & 1) == ((resp(k-1) >> 6) & 1))) stop = k;
      end else begin
        ok = ok && valid_rd(op, data, resp(k));
        if (k == stop + 2) begin
          push(0, 0, 0, 0, 1, ok, 0, "R5/R6/R8 result");
          return;
        end
      end
    end
  endfunction

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (running) begin
      cyc_t e;
      bit bad;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        bad = (fl_we !== e.we) || (fl_re !== e.re) || (req_ready !== 1'b0) || (done !== e.dn);
        if (e.we && ((int'(fl_addr) != e.addr) || (int'(fl_wdata) != e.wd))) bad = 1;
        if (e.re && (int'(fl_addr) != e.addr)) bad = 1;
        if (e.dn && ((pass !== e.ps) || (timed_out !== e.to))) bad = 1;
        n_cmp++;
        if (bad) begin
          n_bad++;
          $display("FAIL %s t=%0t: act we=%b re=%b rdy=%b adr=%h wd=%h dn=%b ps=%b to=%b exp we=%b re=%b rdy=0 adr=%h wd=%h dn=%b ps=%b to=%b",
                   e.tag, $time, fl_we, fl_re, req_ready, fl_addr, fl_wdata, done, pass, timed_out,
                   e.we, e.re, e.addr, e.wd, e.dn, e.ps, e.to);
        end
      end else begin
        n_cmp++;
        if (req_ready !== 1'b1 || fl_we !== 1'b0 || fl_re !== 1'b0 || done !== 1'b0) begin
          n_bad++;
          $display("FAIL R1 idle t=%0t: act rdy=%b we=%b re=%b dn=%b exp rdy=1 we=0 re=0 dn=0",
                   $time, req_ready, fl_we, fl_re, done);
        end
      end
    end
  end

  task automatic do_op(input int op, input int addr, input int data, input bit poke);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_addr  = AW'(addr);
    req_data  = 8'(data);
    @(posedge clk);
    plan(op, addr, data);
    #1 req_valid = 1'b0;
    if (poke) begin
      // R1: a request held during the busy period must change nothing
      repeat (2) @(negedge clk);
      req_valid = 1'b1;
      req_op    = 2'd3;
      req_addr  = '0;
      repeat (5) @(negedge clk);
      req_valid = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic fill_toggle(input int n, input int fin);
    rsp_q.delete();
    for (int k = 0; k < n; k++) rsp_q.push_back((k % 2 == 0) ? 32'h40 : 32'h00);
    rsp_q.push_back(fin);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act run still active exp finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    n_cmp++;
    if (req_ready !== 1'b1 || done !== 1'b0 || pass !== 1'b0 || timed_out !== 1'b0 ||
        fl_we !== 1'b0 || fl_re !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 reset: act rdy=%b dn=%b ps=%b to=%b we=%b re=%b exp 1 0 0 0 0 0",
               req_ready, done, pass, timed_out, fl_we, fl_re);
    end
    rst_n = 1'b1;
    @(negedge clk);
    running = 1;

    // R2 R4 R5 R6: program, stops after three toggles, good confirmation
    tog_forever = 0;
    rsp_q = '{32'h00, 32'h40, 32'h00, 32'hA5, 32'hA5, 32'hA5};
    do_op(0, 32'h3_1234, 32'hA5, 0);
    // R5 R6: program, bit 7 wrong on both confirmation reads
    rsp_q = '{32'h00, 32'h40, 32'h40, 32'h25, 32'h25};
    do_op(0, 32'h0_0042, 32'hA5, 0);
    // R5: bad first confirmation, good second -> fail
    rsp_q = '{32'h40, 32'h40, 32'h25, 32'hA5};
    do_op(0, 32'h0_0100, 32'hA5, 0);
    // R4: completion lands on the read that ends toggling
    rsp_q = '{32'h00, 32'h40, 32'h5A, 32'h5A, 32'h5A};
    do_op(0, 32'h7_FFFF, 32'h5A, 0);
    // R3 R6 R1: sector erase with a request poked while busy
    rsp_q = '{32'h00, 32'h40, 32'h00, 32'hFF, 32'hFF, 32'hFF};
    do_op(1, 32'h1_2345, 32'hFF, 1);
    // R3 R6: block erase, confirmation FEh -> fail
    rsp_q = '{32'h40, 32'h40, 32'hFE, 32'hFF};
    do_op(2, 32'hA_BCDE, 32'h00, 0);
    // R3: chip erase, good
    rsp_q = '{32'h00, 32'h40, 32'hFF, 32'hFF, 32'hFF};
    do_op(3, 32'h0_0000, 32'h00, 0);
    // R7: sector erase ending just inside, then just outside, the window
    fill_toggle(17, 32'hFF);
    do_op(1, 32'h4_0FFF, 32'h00, 0);
    fill_toggle(19, 32'hFF);
    do_op(1, 32'h4_0FFF, 32'h00, 0);
    // R7: endless toggling on program and chip erase
    tog_forever = 1;
    do_op(0, 32'h0_0010, 32'h11, 0);
    do_op(3, 32'h0_0020, 32'h00, 0);
    tog_forever = 0;

    running = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule